// File: doc/BRIEF.md
# Interleaved Memory Block Fetcher

This block serves read requests for whole cache blocks from a group of word-wide memory banks. Consecutive word addresses are spread across the banks by their low-order bits, so the word at address `a` lives in bank `a mod NUM_BANKS`, at row `a / NUM_BANKS`. A block holds exactly one word from each bank. The storage is a simple behavioural model kept inside the block, and it is filled with a known pattern at reset.

A requester presents a block address with a valid/ready handshake. The fetcher spends an address phase, then starts a read in every bank in the same cycle. The banks share one access time. After that the fetcher drives the gathered words one at a time onto a single-word response bus, with one transfer slot per word. A block of N words therefore costs one access time plus N transfer slots. The per-word sequential scheme would pay the full address, access and transfer time for every word.

Only one block is in flight at a time. The request port stays closed until the final word of the current block has been delivered.

Top module: `ilv_block_fetcher`

## Requirements
- R1: Directly after reset, `req_ready` is 1 and `rsp_valid` is 0.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. From the cycle after acceptance through the cycle that carries the last word, `req_ready` is 0.
- R3: For block address B, the word with index k carries the contents of word address a = B*NUM_BANKS + k. That word is held in bank k at row B. The reset fill of word address a is ((a as 32 bits) * 0x9E3779B1) XOR 0x5A5A5A5A, taken modulo 2^32 and resized to WORD_W.
- R4: The words of a block come out in ascending index order 0 to NUM_BANKS-1 on `rsp_idx`. `rsp_last` is 1 only together with the word whose index is NUM_BANKS-1.
- R5: Count the acceptance cycle as cycle 0. Word k is presented, with `rsp_valid` 1, in cycle ADDR_CYC + ACCESS_CYC + (k+1)*XFER_CYC, and `rsp_valid` is 0 in every other cycle. With the default parameters this gives cycles 32, 36, 40 and 44.
- R6: All banks are read in parallel and return their words in the same cycle. The last word of a block therefore arrives ADDR_CYC + ACCESS_CYC + NUM_BANKS*XFER_CYC cycles after acceptance (44 by default), not NUM_BANKS*(ADDR_CYC + ACCESS_CYC + XFER_CYC) cycles (128 by default).
- R7: `req_ready` is 1 in the cycle right after the last word. A request held valid at that point is accepted there, with no idle cycle in between.
- R8: While a block is in flight, `req_valid` and `req_addr` have no effect. The words delivered belong to the address captured at acceptance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Block request present |
| req_ready | output | 1 | Fetcher idle and able to accept a request |
| req_addr | input | ADDR_W - log2(NUM_BANKS) | Block address (word address divided by NUM_BANKS) |
| rsp_valid | output | 1 | A word of the block is on the response bus this cycle |
| rsp_data | output | WORD_W | Word data, zero when `rsp_valid` is 0 |
| rsp_idx | output | log2(NUM_BANKS) | Position of the word within its block |
| rsp_last | output | 1 | Final word of the block |

## Verification
Some properties are checked on every cycle by the assertions. When all banks must have finished, they do finish together and never separately. A response word never appears while the request port is open. The word index only ever steps up by one within a block, and the last flag comes only with the top index. The port reopens the cycle after the last word, and no bank is restarted while it is still busy.

Other behaviour can only be shown by the bench's scenarios. These cover the exact arrival cycle of each word, the data values at the first, last and random blocks, immunity to address changes while a block is in flight, and back-to-back acceptance.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ADDR   = 2'd1,
        ST_ACCESS = 2'd2,
        ST_XFER   = 2'd3
    } fetch_state_e;

    localparam logic [31:0] FILL_MULT = 32'h9E37_79B1;
    localparam logic [31:0] FILL_XOR  = 32'h5A5A_5A5A;

    function automatic logic [31:0] fill_word(input logic [31:0] word_addr);
        return (word_addr * FILL_MULT) ^ FILL_XOR;
    endfunction

endpackage

// File: rtl/ilv_bank.sv
module ilv_bank #(
    parameter int WORD_W     = 32,
    parameter int ROW_W      = 6,
    parameter int NUM_BANKS  = 4,
    parameter int BANK_ID    = 0,
    parameter int ACCESS_CYC = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ROW_W-1:0]  rd_row,
    output logic              rd_valid,
    output logic [WORD_W-1:0] rd_data
);
    import ilv_pkg::*;

    localparam int ROWS  = 2 ** ROW_W;
    localparam int CNT_W = $clog2(ACCESS_CYC + 1);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
        logic [ROW_W-1:0] row;
    } bank_t;

    bank_t bank_d, bank_q;
    logic [WORD_W-1:0] mem [ROWS];

    always_comb begin
        bank_d   = bank_q;
        rd_valid = 1'b0;
        if (bank_q.busy) begin
            if (bank_q.cnt == '0) begin
                rd_valid    = 1'b1;
                bank_d.busy = 1'b0;
            end else begin
                bank_d.cnt = bank_q.cnt - 1'b1;
            end
        end
        if (rd_en) begin
            bank_d.busy = 1'b1;
            bank_d.cnt  = CNT_W'(ACCESS_CYC - 1);
            bank_d.row  = rd_row;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    // Behavioural storage: filled with the known pattern at reset, read-only afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < ROWS; r++) begin
                mem[r] <= WORD_W'(fill_word(32'(r * NUM_BANKS + BANK_ID)));
            end
        end
    end

    assign rd_data = rd_valid ? mem[bank_q.row] : '0;

    // R2: the controller never restarts a bank that is still busy.
    p_no_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> !bank_q.busy);

endmodule

// File: rtl/ilv_fetch_ctrl.sv
module ilv_fetch_ctrl #(
    parameter int NUM_BANKS  = 4,
    parameter int WORD_W     = 32,
    parameter int BLK_W      = 6,
    parameter int ADDR_CYC   = 4,
    parameter int ACCESS_CYC = 24,
    parameter int XFER_CYC   = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              req_valid,
    output logic                              req_ready,
    input  logic [BLK_W-1:0]                  req_addr,
    output logic                              bank_rd_en,
    output logic [BLK_W-1:0]                  bank_row,
    input  logic [NUM_BANKS-1:0]              bank_valid,
    input  logic [NUM_BANKS-1:0][WORD_W-1:0]  bank_data,
    output logic                              rsp_valid,
    output logic [WORD_W-1:0]                 rsp_data,
    output logic [$clog2(NUM_BANKS)-1:0]      rsp_idx,
    output logic                              rsp_last
);
    import ilv_pkg::*;

    localparam int IDX_W  = $clog2(NUM_BANKS);
    localparam int MAX_AX = (ADDR_CYC > ACCESS_CYC) ? ADDR_CYC : ACCESS_CYC;
    localparam int MAXC   = (MAX_AX > XFER_CYC) ? MAX_AX : XFER_CYC;
    localparam int CNT_W  = $clog2(MAXC + 1);
    localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(NUM_BANKS - 1);

    typedef struct packed {
        fetch_state_e                     state;
        logic [CNT_W-1:0]                 cnt;
        logic [BLK_W-1:0]                 blk;
        logic [IDX_W-1:0]                 idx;
        logic [NUM_BANKS-1:0][WORD_W-1:0] words;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d = ctrl_q;
        unique case (ctrl_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    ctrl_d.state = ST_ADDR;
                    ctrl_d.cnt   = CNT_W'(ADDR_CYC - 1);
                    ctrl_d.blk   = req_addr;
                end
            end
            ST_ADDR: begin
                if (ctrl_q.cnt == '0) begin
                    ctrl_d.state = ST_ACCESS;
                    ctrl_d.cnt   = CNT_W'(ACCESS_CYC - 1);
                end else begin
                    ctrl_d.cnt = ctrl_q.cnt - 1'b1;
                end
            end
            ST_ACCESS: begin
                if (ctrl_q.cnt == '0) begin
                    ctrl_d.words = bank_data;
                    ctrl_d.state = ST_XFER;
                    ctrl_d.cnt   = CNT_W'(XFER_CYC - 1);
                    ctrl_d.idx   = '0;
                end else begin
                    ctrl_d.cnt = ctrl_q.cnt - 1'b1;
                end
            end
            ST_XFER: begin
                if (ctrl_q.cnt == '0) begin
                    if (ctrl_q.idx == TOP_IDX) begin
                        ctrl_d.state = ST_IDLE;
                    end else begin
                        ctrl_d.idx = ctrl_q.idx + 1'b1;
                        ctrl_d.cnt = CNT_W'(XFER_CYC - 1);
                    end
                end else begin
                    ctrl_d.cnt = ctrl_q.cnt - 1'b1;
                end
            end
            default: ctrl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign req_ready  = (ctrl_q.state == ST_IDLE);
    assign bank_rd_en = (ctrl_q.state == ST_ADDR) && (ctrl_q.cnt == '0);
    assign bank_row   = ctrl_q.blk;
    assign rsp_valid  = (ctrl_q.state == ST_XFER) && (ctrl_q.cnt == '0);
    assign rsp_idx    = ctrl_q.idx;
    assign rsp_last   = rsp_valid && (ctrl_q.idx == TOP_IDX);
    assign rsp_data   = rsp_valid ? ctrl_q.words[ctrl_q.idx] : '0;

    // R6: every bank has its word ready when the shared access window closes.
    p_banks_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.state == ST_ACCESS && ctrl_q.cnt == '0) |-> (&bank_valid));

    // R6: banks finish all together or not at all.
    p_banks_together_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(bank_valid) == 0) || ($countones(bank_valid) == NUM_BANKS));

    // R2: no response word while the request port is open.
    p_closed_port_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);

    // R4: the last flag comes only with the top index.
    p_last_top_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_last |-> (rsp_valid && rsp_idx == TOP_IDX));

    // R4: within a block the index steps up by one after each word.
    p_idx_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_last) |=> (rsp_idx == $past(rsp_idx) + 1'b1));

    // R7: the port reopens right after the final word.
    p_reopen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_last |=> req_ready);

endmodule

// File: rtl/ilv_block_fetcher.sv
module ilv_block_fetcher #(
    parameter int NUM_BANKS  = 4,
    parameter int WORD_W     = 32,
    parameter int ADDR_W     = 8,
    parameter int ADDR_CYC   = 4,
    parameter int ACCESS_CYC = 24,
    parameter int XFER_CYC   = 4
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  req_valid,
    output logic                                  req_ready,
    input  logic [ADDR_W-$clog2(NUM_BANKS)-1:0]   req_addr,
    output logic                                  rsp_valid,
    output logic [WORD_W-1:0]                     rsp_data,
    output logic [$clog2(NUM_BANKS)-1:0]          rsp_idx,
    output logic                                  rsp_last
);
    localparam int BANK_SEL_W = $clog2(NUM_BANKS);
    localparam int BLK_W      = ADDR_W - BANK_SEL_W;

    logic                             bank_rd_en;
    logic [BLK_W-1:0]                 bank_row;
    logic [NUM_BANKS-1:0]             bank_valid;
    logic [NUM_BANKS-1:0][WORD_W-1:0] bank_data;

    ilv_fetch_ctrl #(
        .NUM_BANKS (NUM_BANKS),
        .WORD_W    (WORD_W),
        .BLK_W     (BLK_W),
        .ADDR_CYC  (ADDR_CYC),
        .ACCESS_CYC(ACCESS_CYC),
        .XFER_CYC  (XFER_CYC)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_addr  (req_addr),
        .bank_rd_en(bank_rd_en),
        .bank_row  (bank_row),
        .bank_valid(bank_valid),
        .bank_data (bank_data),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data),
        .rsp_idx   (rsp_idx),
        .rsp_last  (rsp_last)
    );

    // One bank per low-order word-address value; all share the row and the start strobe.
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        ilv_bank #(
            .WORD_W    (WORD_W),
            .ROW_W     (BLK_W),
            .NUM_BANKS (NUM_BANKS),
            .BANK_ID   (b),
            .ACCESS_CYC(ACCESS_CYC)
        ) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .rd_en   (bank_rd_en),
            .rd_row  (bank_row),
            .rd_valid(bank_valid[b]),
            .rd_data (bank_data[b])
        );
    end

endmodule

// File: tb/ilv_block_fetcher_test.sv
module ilv_block_fetcher_test;

    localparam int NB     = 4;
    localparam int WW     = 32;
    localparam int AW     = 8;
    localparam int TA     = 4;
    localparam int TACC   = 24;
    localparam int TX     = 4;
    localparam int IW     = $clog2(NB);
    localparam int BW     = AW - IW;
    localparam int L_LAST = TA + TACC + NB * TX;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [BW-1:0] req_addr = '0;
    logic          rsp_valid;
    logic [WW-1:0] rsp_data;
    logic [IW-1:0] rsp_idx;
    logic          rsp_last;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    ilv_block_fetcher #(
        .NUM_BANKS(NB), .WORD_W(WW), .ADDR_W(AW),
        .ADDR_CYC(TA), .ACCESS_CYC(TACC), .XFER_CYC(TX)
    ) uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_idx(rsp_idx), .rsp_last(rsp_last)
    );

    function automatic logic [WW-1:0] ref_word(input int blk, input int k);
        logic [31:0] a;
        a = 32'(blk * NB + k);
        return WW'((a * 32'h9E37_79B1) ^ 32'h5A5A_5A5A);
    endfunction

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Called at a negedge; returns at a negedge after the port has reopened.
    task automatic fetch_block(input int blk, input bit noise);
        int last_cycle;
        bit exp_v;
        int k;
        last_cycle = -1;
        check(req_ready == 1'b1, "R7 ready before request", 64'(req_ready), 64'd1);
        req_valid = 1'b1;
        req_addr  = BW'(blk);
        @(posedge clk);
        for (int j = 1; j <= L_LAST + 1; j++) begin
            @(negedge clk);
            exp_v = (j >= TA + TACC + TX) && (j <= L_LAST) && (((j - TA - TACC) % TX) == 0);
            check(rsp_valid == exp_v, "R5 valid timing", 64'(rsp_valid), 64'(exp_v));
            if (j <= L_LAST)
                check(req_ready == 1'b0, "R2 ready low in flight", 64'(req_ready), 64'd0);
            else
                check(req_ready == 1'b1, "R7 ready after last", 64'(req_ready), 64'd1);
            if (rsp_valid && exp_v) begin
                k = (j - TA - TACC) / TX - 1;
                check(rsp_data == ref_word(blk, k), noise ? "R8 data under noise" : "R3 word data",
                      64'(rsp_data), 64'(ref_word(blk, k)));
                check(rsp_idx == IW'(k), "R4 word index", 64'(rsp_idx), 64'(k));
                check(rsp_last == (k == NB - 1), "R4 last flag", 64'(rsp_last), 64'(k == NB - 1));
                if (rsp_last) last_cycle = j;
            end
            if (j <= L_LAST && noise) begin
                req_valid = 1'b1;
                req_addr  = BW'($urandom);
            end else begin
                req_valid = 1'b0;
            end
        end
        check(last_cycle == L_LAST, "R6 block latency", 64'(last_cycle), 64'(L_LAST));
        check(last_cycle != NB * (TA + TACC + TX), "R6 not sequential", 64'(last_cycle),
              64'(NB * (TA + TACC + TX)));
    endtask

    task automatic idle_gap(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check(rsp_valid == 1'b0, "R5 no word while idle", 64'(rsp_valid), 64'd0);
            check(req_ready == 1'b1, "R1 ready while idle", 64'(req_ready), 64'd1);
        end
    endtask

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'h1F3A_77C5);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1, "R1 reset ready", 64'(req_ready), 64'd1);
        check(rsp_valid == 1'b0, "R1 reset valid", 64'(rsp_valid), 64'd0);

        // Directed corners: first block, top block, a middle one, back-to-back (R7).
        fetch_block(0, 1'b0);
        fetch_block((1 << BW) - 1, 1'b0);
        fetch_block(21, 1'b1);
        idle_gap(2);

        // Random blocks, random noise while busy (R8) and random idle gaps.
        for (int n = 0; n < 24; n++) begin
            fetch_block(int'($urandom_range((1 << BW) - 1, 0)), 1'($urandom));
            idle_gap(int'($urandom_range(2, 0)));
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule